// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a 16-bit physical address through a four-entry segment table held in registers. The two most significant address bits pick one table entry and the twelve bits below them give the offset into that segment. Every entry has a valid bit, a physical base, a length and three permission bits (read, write, execute). A lookup does one of two things. It produces base plus offset, or it reports a fault with a 2-bit cause. The cause tells software which rule failed: an empty entry, a length or overflow violation, or an access type the segment does not allow. A write to a read-only segment can therefore be told apart from an out-of-range access, for example when software shares a segment between processes and copies it only when one of them writes.

Requests and responses travel on valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the response register is empty or is being emptied in the same cycle (`rsp_ready` high). The result is held in one output register. It stays unchanged for as long as `rsp_valid` is high and `rsp_ready` is low. The lookup logic is combinational up to that register. Privileged software loads the table through a plain write port. A write takes effect for requests accepted after the edge on which it is written.

Top module: `segxlate_unit`

## Requirements
- R1: After reset `rsp_valid` is low and all four table entries are invalid, so any request made before a table write faults with cause 3.
- R2: Bits [13:12] of `req_vaddr` select the table entry and bits [11:0] form the offset.
- R3: For a valid entry that allows the access, with offset below the length and no carry out of bit 15, the response has `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = base + offset.
- R4: An offset greater than or equal to the entry length gives `rsp_fault`=1 and `rsp_cause`=1 (bounds). On every faulting response `rsp_paddr` is 0.
- R5: If base + offset carries out of the 16-bit physical address, the response is a bounds fault (cause 1) and the sum is not reported wrapped.
- R6: Permission bits are bit 0 read, bit 1 write and bit 2 execute. Access type 00 is read, 01 is write and 10 is fetch. The access faults with cause 2 when its bit is clear. Type 11 always faults with cause 2.
- R7: An access to an entry whose valid bit is clear faults with cause 3. Cause priority runs invalid (3) first, then bounds (1), then permission (2).
- R8: Entries are checked on their own. Two entries with the same base and length but different permissions give different results for the same access type.
- R9: A table write on a given clock edge is not seen by a request accepted on that same edge, and is seen by every request accepted later.
- R10: A request accepted on one edge gives `rsp_valid` high after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` low, every response output stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 14 | Virtual address: entry select in [13:12], offset in [11:0] |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 bounds, 2 permission, 3 invalid entry |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Entry to write |
| tbl_valid | input | 1 | Valid bit for the written entry |
| tbl_start | input | 16 | Physical base for the written entry |
| tbl_len | input | 13 | Segment length in bytes (0 to 4096) |
| tbl_perm | input | 3 | Permission bits {execute, write, read} |

## Verification
The lookup is tried with the offset at length minus one and at exactly the length, which separates a correct strict bound from an inclusive one. It is also tried with a base near the top of the physical space, where the sum either just fits or carries out, which shows whether overflow is caught or wraps. Two entries with identical base and length but different permissions take reads, writes, fetches and the reserved type, to show that the entry select and the per-entry permission decode are separate. The same requests repeat under random back-pressure. One table write lands on the same edge as a request, to tell old-entry from new-entry lookup.

// File: rtl/segxlate_pkg.sv
package segxlate_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_t;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_BOUND = 2'd1,
    CAUSE_PERM  = 2'd2,
    CAUSE_INVAL = 2'd3
  } cause_t;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;

endpackage

// File: rtl/segxlate_table.sv
module segxlate_table #(
  parameter int SEL_W  = 2,
  parameter int PA_W   = 16,
  parameter int LEN_W  = 13,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_vld,
  input  logic [PA_W-1:0]   wr_start,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              rd_vld,
  output logic [PA_W-1:0]   rd_start,
  output logic [LEN_W-1:0]  rd_len,
  output logic [PERM_W-1:0] rd_perm
);
  localparam int NUM = 1 << SEL_W;

  logic              vld_a   [NUM];
  logic [PA_W-1:0]   start_a [NUM];
  logic [LEN_W-1:0]  len_a   [NUM];
  logic [PERM_W-1:0] perm_a  [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    logic              vld_q;
    logic [PA_W-1:0]   start_q;
    logic [LEN_W-1:0]  len_q;
    logic [PERM_W-1:0] perm_q;
    logic              hit;

    assign hit = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q   <= 1'b0;
        start_q <= '0;
        len_q   <= '0;
        perm_q  <= '0;
      end else if (hit) begin
        vld_q   <= wr_vld;
        start_q <= wr_start;
        len_q   <= wr_len;
        perm_q  <= wr_perm;
      end
    end

    assign vld_a[g]   = vld_q;
    assign start_a[g] = start_q;
    assign len_a[g]   = len_q;
    assign perm_a[g]  = perm_q;
  end

  assign rd_vld   = vld_a[rd_sel];
  assign rd_start = start_a[rd_sel];
  assign rd_len   = len_a[rd_sel];
  assign rd_perm  = perm_a[rd_sel];
endmodule

// File: rtl/segxlate_check.sv
module segxlate_check
  import segxlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  parameter int LEN_W = OFF_W + 1
) (
  input  logic              ent_vld,
  input  logic [PA_W-1:0]   ent_start,
  input  logic [LEN_W-1:0]  ent_len,
  input  logic [PERM_W-1:0] ent_perm,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        acc,
  output logic [PA_W-1:0]   paddr,
  output logic              fault,
  output logic [1:0]        cause
);
  localparam int SUM_W = PA_W + 1;

  logic [SUM_W-1:0] sum;
  logic             over_len;
  logic             carry;
  logic             allowed;

  assign sum      = {1'b0, ent_start} + SUM_W'(offset);
  assign carry    = sum[PA_W];
  assign over_len = LEN_W'(offset) >= ent_len;

  always_comb begin
    unique case (acc_t'(acc))
      ACC_RD:  allowed = ent_perm[PERM_RD];
      ACC_WR:  allowed = ent_perm[PERM_WR];
      ACC_EX:  allowed = ent_perm[PERM_EX];
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    cause = CAUSE_NONE;
    if (!ent_vld)                cause = CAUSE_INVAL;
    else if (over_len || carry)  cause = CAUSE_BOUND;
    else if (!allowed)           cause = CAUSE_PERM;
    fault = (cause != CAUSE_NONE);
    paddr = fault ? '0 : sum[PA_W-1:0];
  end
endmodule

// File: rtl/segxlate_rsp.sv
module segxlate_rsp #(
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_fault,
  input  logic [1:0]      in_cause,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_fault,
  output logic [1:0]      out_cause
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_fault <= 1'b0;
      out_cause <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_paddr <= in_paddr;
        out_fault <= in_fault;
        out_cause <= in_cause;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/segxlate_unit.sv
module segxlate_unit
  import segxlate_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  localparam int VA_W  = SEL_W + OFF_W,
  localparam int LEN_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  input  logic              tbl_we,
  input  logic [SEL_W-1:0]  tbl_sel,
  input  logic              tbl_valid,
  input  logic [PA_W-1:0]   tbl_start,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic [PERM_W-1:0] tbl_perm
);
  logic [SEL_W-1:0]  seg_sel;
  logic [OFF_W-1:0]  seg_off;
  logic              e_vld;
  logic [PA_W-1:0]   e_start;
  logic [LEN_W-1:0]  e_len;
  logic [PERM_W-1:0] e_perm;
  logic [PA_W-1:0]   x_paddr;
  logic              x_fault;
  logic [1:0]        x_cause;

  assign seg_sel = req_vaddr[VA_W-1 -: SEL_W];
  assign seg_off = req_vaddr[OFF_W-1:0];

  segxlate_table #(
    .SEL_W(SEL_W), .PA_W(PA_W), .LEN_W(LEN_W), .PERM_W(PERM_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_sel(tbl_sel), .wr_vld(tbl_valid),
    .wr_start(tbl_start), .wr_len(tbl_len), .wr_perm(tbl_perm),
    .rd_sel(seg_sel), .rd_vld(e_vld), .rd_start(e_start),
    .rd_len(e_len), .rd_perm(e_perm)
  );

  segxlate_check #(
    .OFF_W(OFF_W), .PA_W(PA_W), .LEN_W(LEN_W)
  ) u_check (
    .ent_vld(e_vld), .ent_start(e_start), .ent_len(e_len), .ent_perm(e_perm),
    .offset(seg_off), .acc(req_acc),
    .paddr(x_paddr), .fault(x_fault), .cause(x_cause)
  );

  segxlate_rsp #(.PA_W(PA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_paddr(x_paddr), .in_fault(x_fault), .in_cause(x_cause),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_paddr(rsp_paddr), .out_fault(rsp_fault), .out_cause(rsp_cause)
  );
endmodule

// File: rtl/segxlate_chk.sv
module segxlate_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                   && $stable(rsp_fault) && $stable(rsp_cause)));

  // R10
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  resp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // R4
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  // R7
  cause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));
endmodule

bind segxlate_unit segxlate_chk #(.PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
);

// File: tb/segxlate_unit_tb_top.sv
module segxlate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sel = '0;
  logic        tbl_valid = 1'b0;
  logic [15:0] tbl_start = '0;
  logic [12:0] tbl_len = '0;
  logic [2:0]  tbl_perm = '0;

  always #10 clk = ~clk;  // 50 MHz

  segxlate_unit dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit bp_on  = 1'b0;
  string phase = "R1";

  // behavioural reference: table and one-deep response slot
  int  t_vld [4];
  int  t_start [4];
  int  t_len [4];
  int  t_perm [4];
  bit  m_valid = 1'b0;
  int  m_pa, m_fault, m_cause;

  function automatic void expect_of(input int va, input int acc,
                                    output int pa, output int f, output int c);
    int s, o, bitn;
    s = (va >> 12) & 3;  // R2
    o = va & 12'hFFF;
    bitn = (acc == 0) ? 0 : (acc == 1) ? 1 : (acc == 2) ? 2 : -1;
    if (t_vld[s] == 0) c = 3;                                   // R7
    else if (o >= t_len[s] || t_start[s] + o > 65535) c = 1;     // R4 R5
    else if (bitn < 0 || ((t_perm[s] >> bitn) & 1) == 0) c = 2;  // R6
    else c = 0;
    f  = (c != 0);
    pa = f ? 0 : t_start[s] + o;                                 // R3
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
        t_vld[i] = 0; t_start[i] = 0; t_len[i] = 0; t_perm[i] = 0;
      end
    end else begin
      bit acc_now;
      acc_now = req_valid && (!m_valid || rsp_ready);
      if (m_valid && rsp_ready) m_valid = 1'b0;
      if (acc_now) begin  // R9: lookup uses the table before this edge's write
        expect_of(int'(req_vaddr), int'(req_acc), m_pa, m_fault, m_cause);
        m_valid = 1'b1;
      end
      if (tbl_we) begin
        t_vld[tbl_sel]   = tbl_valid;
        t_start[tbl_sel] = tbl_start;
        t_len[tbl_sel]   = tbl_len;
        t_perm[tbl_sel]  = tbl_perm;
      end
    end
  end

  function automatic string tag_of(input int c);
    case (c)
      0: return "R3";
      1: return "R4/R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (req_ready !== (!m_valid || rsp_ready)) begin
        fails++;
        $display("FAIL R10 req_ready actual=%b expected=%b", req_ready, (!m_valid || rsp_ready));
      end
      checks++;
      if (rsp_valid !== m_valid) begin
        fails++;
        $display("FAIL R10 (%s) rsp_valid actual=%b expected=%b", phase, rsp_valid, m_valid);
      end
      if (m_valid && rsp_valid) begin
        checks++;
        if (rsp_fault !== m_fault[0] || rsp_cause !== m_cause[1:0] || rsp_paddr !== m_pa[15:0]) begin
          fails++;
          $display("FAIL %s (%s) actual f=%b c=%0d pa=%h expected f=%0d c=%0d pa=%h",
                   tag_of(m_cause), phase, rsp_fault, rsp_cause, rsp_paddr, m_fault, m_cause, m_pa[15:0]);
        end
      end
    end
  end

  // back-pressure generator
  always @(negedge clk) begin
    #2 rsp_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic send(input int va, input int acc);
    bit got;
    @(negedge clk); #3;
    req_valid = 1'b1; req_vaddr = 14'(va); req_acc = 2'(acc);
    got = 1'b0;
    while (!got) begin
      #1 got = req_ready;
      @(negedge clk); #3;
    end
    req_valid = 1'b0;
  endtask

  task automatic load(input int sel, input int v, input int st, input int ln, input int pm);
    @(negedge clk); #3;
    tbl_we = 1'b1; tbl_sel = 2'(sel); tbl_valid = v[0];
    tbl_start = 16'(st); tbl_len = 13'(ln); tbl_perm = 3'(pm);
    @(negedge clk); #3;
    tbl_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, rsp_valid low before anything happens
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 rsp_valid after reset actual=%b expected=0", rsp_valid);
    end
    rst_n = 1'b1;
    phase = "R1";
    send(14'h0010, 0);  // R1 R7: table empty after reset
    send(14'h3FFF, 1);
    phase = "R8";
    load(0, 1, 16'h4000, 16'h100, 3'b101);  // R+X
    load(1, 1, 16'h4000, 16'h100, 3'b011);  // R+W, same base and length
    load(2, 1, 16'hFF00, 16'h1000, 3'b111);
    load(3, 0, 16'h0000, 0, 3'b000);
    for (int a = 0; a < 4; a++) begin  // R6 R8 all access types on twin entries
      send(14'h0020, a);
      send(14'h1020, a);
    end
    phase = "R4";
    send(14'h00FF, 0);  // last byte inside
    send(14'h0100, 0);  // exactly at length
    send(14'h0100, 1);  // bounds outranks permission
    phase = "R5";
    send(14'h20FF, 0);  // sum 0xFFFF fits
    send(14'h2100, 0);  // carries out
    phase = "R7";
    send(14'h3000, 0);  // invalid outranks bounds (len 0)
    phase = "R2";
    for (int s = 0; s < 4; s++) send((s << 12) | 12'h0AB, 0);
    phase = "R9";
    // same-edge write and request: request must see old entry 0 (R+X, no W)
    @(negedge clk); #3;
    req_valid = 1'b1; req_vaddr = 14'h0004; req_acc = 2'd1;
    tbl_we = 1'b1; tbl_sel = 2'd0; tbl_valid = 1'b1;
    tbl_start = 16'h1000; tbl_len = 13'h800; tbl_perm = 3'b010;
    @(negedge clk); #3;
    tbl_we = 1'b0; req_valid = 1'b0;
    send(14'h0004, 1);  // R9 now sees new entry
    phase = "R10";
    bp_on = 1'b1;
    load(3, 1, 16'h8000, 16'h1000, 3'b001);
    for (int i = 0; i < 300; i++) send(int'($urandom_range(0, 16383)), int'($urandom_range(0, 3)));
    bp_on = 1'b0;
    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule